// File: doc/BRIEF.md
# Infrared Link Mode Select and Interrupt Aggregator

This block holds the transfer-mode selection of an infrared serial link and turns the event pulses of the link datapath into a single level interrupt. A small synchronous register port lets software pick one of three link speeds and manage two banks of event flags. The slow-speed bank is used when the slow mode is selected. The shared medium/fast bank is used when either faster mode is selected.

Each bank has a sticky source register, a mask register and a write-one-to-clear register. Two of the event positions change meaning with the bank. In the slow bank, bit 9 flags a receive timeout and bit 8 flags a framing error. In the medium/fast bank, the same positions flag an abort and a CRC error. Three group-mask bits in the mode register gate each bank and a level request from the receive FIFO before they reach the interrupt line. Software reads the source register to see what happened, clears it, and can poll events that it keeps masked.

Top module: `irda_mic_top`

## Requirements
- R1: After reset, the mode register reads 0x0111 (field 00, all three group masks set), both mask registers read 0x8B80, both source registers read 0x0000, and irqOut is 0.
- R2: The register port decodes these addresses: 0 mode, 1 slow source, 2 slow mask, 3 slow clear, 4 medium/fast source, 5 medium/fast mask, 6 medium/fast clear. Clear addresses and address 7 read 0. In the mode register, only bits 15:14 (the mode field) and bits 8, 4 and 0 are stored; every other bit reads 0.
- R3: evtPulse maps to source bits as follows: bit 0 (frame received) to bit 15, bit 1 (transfer area overflow) to bit 11, bit 2 (timeout or abort) to bit 9, bit 3 (framing or CRC error) to bit 8, and bit 4 (frame sent) to bit 7. With the mode field at 00 the pulses set the slow bank. At 11 or 10 they set the medium/fast bank. At 01 they set nothing.
- R4: A source bit is set by its event whatever the mask state and stays set until cleared. Writes to a source address have no effect.
- R5: Writing a word to a clear address clears each source bit of that bank whose matching data bit is 1. Data bits that are 0 leave their source bits unchanged.
- R6: If an event and a clear hit the same source bit in the same cycle, the bit ends up set.
- R7: A mask register stores only bits 15, 11, 9, 8 and 7. A set mask bit keeps its source bit from driving irqOut.
- R8: irqOut is 1 when any of three conditions holds. The slow bank has a set, unmasked source bit while mode bit 0 is 0. The medium/fast bank has a set, unmasked source bit while mode bit 4 is 0. fifoIrqIn is 1 while mode bit 8 is 0.
- R9: irqOut follows register and source changes in the cycle after the clock edge that updates them, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWData | input | 16 | Write data |
| regRData | output | 16 | Read data of the addressed register (combinational) |
| evtPulse | input | 5 | One-cycle event pulses from the link datapath |
| fifoIrqIn | input | 1 | Level request from the receive FIFO group |
| irqOut | output | 1 | Aggregated level interrupt |

## Verification
The bench builds the block with its default three-bit address. This keeps the whole register map, including the unused address 7, inside a full sweep. It covers every combination of the four mode-field codes and the five event inputs. For each combination it walks through the per-bit mask, the group mask and the clear register, and it computes the expected source word and interrupt level from the bit mapping. The reserved mode code, a clear that collides with an event, writes to the read-only source registers, and the FIFO group request each get their own directed cases.

// File: rtl/irda_mic_pkg.sv
package irda_mic_pkg;

  localparam int DATA_W = 16;
  localparam int EVT_N  = 5;
  localparam int BANK_N = 2;

  // Bit positions that exist in source and mask words
  localparam logic [DATA_W-1:0] EVT_BITS  = 16'h8B80;
  // Bits stored in the mode register
  localparam logic [DATA_W-1:0] MODE_BITS = 16'hC111;
  localparam logic [DATA_W-1:0] MODE_RST  = 16'h0111;

  typedef enum logic [1:0] {
    MODE_SLOW = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FAST = 2'b10,
    MODE_MED  = 2'b11
  } xferMode_e;

  typedef struct packed {
    logic              modeWr;
    logic [BANK_N-1:0] maskWr;
    logic [BANK_N-1:0] clrWr;
    logic [BANK_N-1:0] evtEn;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] evtToBits(input logic [EVT_N-1:0] e);
    logic [DATA_W-1:0] b;
    b     = '0;
    b[15] = e[0];
    b[11] = e[1];
    b[9]  = e[2];
    b[8]  = e[3];
    b[7]  = e[4];
    return b;
  endfunction

  // Group mask bit in the mode register for each bank
  function automatic int grpBit(input int bank);
    return (bank == 0) ? 0 : 4;
  endfunction

  // Base register address of each bank
  function automatic int bankBase(input int bank);
    return 1 + 3 * bank;
  endfunction

  localparam int FIFO_GRP_BIT = 8;

endpackage

// File: rtl/irda_mic_ctrl.sv
module irda_mic_ctrl
  import irda_mic_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        modeField,
  output ctlStrobe_t        strb
);

  always_comb begin
    strb        = '0;
    strb.modeWr = regWr && (regAddr == ADDR_W'(0));
    for (int b = 0; b < BANK_N; b++) begin
      strb.maskWr[b] = regWr && (regAddr == ADDR_W'(bankBase(b) + 1));
      strb.clrWr[b]  = regWr && (regAddr == ADDR_W'(bankBase(b) + 2));
    end
    case (xferMode_e'(modeField))
      MODE_SLOW: strb.evtEn = BANK_N'(1);
      MODE_FAST,
      MODE_MED:  strb.evtEn = BANK_N'(2);
      default:   strb.evtEn = '0;
    endcase
  end

endmodule

// File: rtl/irda_mic_bank.sv
module irda_mic_bank
  import irda_mic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtEn,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic              maskWr,
  input  logic              clrWr,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] srcQ,
  output logic [DATA_W-1:0] maskQ,
  output logic              pending
);

  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] srcNext;

  always_comb begin
    setVec  = evtEn ? evtToBits(evtPulse) : '0;
    clrVec  = clrWr ? (wData & EVT_BITS) : '0;
    srcNext = (srcQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      maskQ <= EVT_BITS;
    end else begin
      srcQ <= srcNext;
      if (maskWr) maskQ <= wData & EVT_BITS;
    end
  end

  assign pending = |(srcQ & ~maskQ);

  a_r4_source_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((srcQ & $past(srcQ)) == $past(srcQ)));

  a_r5_clear_drops_bit: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && wData[15] && !(evtEn && evtPulse[0])) |=> !srcQ[15]);

  a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && wData[8] && evtEn && evtPulse[3]) |=> srcQ[8]);

  a_r3_event_sets_bit: assert property (@(posedge clk) disable iff (!rstN)
    (evtEn && evtPulse[4]) |=> srcQ[7]);

  a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(maskQ));

endmodule

// File: rtl/irda_mic_datapath.sv
module irda_mic_datapath
  import irda_mic_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic              fifoIrqIn,
  output logic [DATA_W-1:0] regRData,
  output logic [1:0]        modeField,
  output logic              irqOut
);

  logic [DATA_W-1:0] modeQ;
  logic [DATA_W-1:0] srcQ  [BANK_N];
  logic [DATA_W-1:0] maskQ [BANK_N];
  logic [BANK_N-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_RST;
    else if (strb.modeWr) modeQ <= regWData & MODE_BITS;
  end

  assign modeField = modeQ[15:14];

  for (genvar b = 0; b < BANK_N; b++) begin : gBank
    irda_mic_bank uBank (
      .clk     (clk),
      .rstN    (rstN),
      .evtEn   (strb.evtEn[b]),
      .evtPulse(evtPulse),
      .maskWr  (strb.maskWr[b]),
      .clrWr   (strb.clrWr[b]),
      .wData   (regWData),
      .srcQ    (srcQ[b]),
      .maskQ   (maskQ[b]),
      .pending (pending[b])
    );
  end

  always_comb begin
    regRData = '0;
    if (regAddr == ADDR_W'(0)) regRData = modeQ;
    for (int b = 0; b < BANK_N; b++) begin
      if (regAddr == ADDR_W'(bankBase(b)))     regRData = srcQ[b];
      if (regAddr == ADDR_W'(bankBase(b) + 1)) regRData = maskQ[b];
    end
  end

  always_comb begin
    irqOut = fifoIrqIn && !modeQ[FIFO_GRP_BIT];
    for (int b = 0; b < BANK_N; b++) begin
      if (pending[b] && !modeQ[grpBit(b)]) irqOut = 1'b1;
    end
  end

  a_r8_all_groups_closed: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[0] && modeQ[4] && modeQ[8]) |-> !irqOut);

  a_r3_reserved_mode_drops: assert property (@(posedge clk) disable iff (!rstN)
    (modeField == 2'b01 && !strb.modeWr && strb.clrWr == '0)
      |=> ($stable(srcQ[0]) && $stable(srcQ[1])));

  a_r2_mode_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> ((modeQ & ~MODE_BITS) == '0));

endmodule

// File: rtl/irda_mic_top.sv
module irda_mic_top
  import irda_mic_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [15:0]       regWData,
  output logic [15:0]       regRData,
  input  logic [4:0]        evtPulse,
  input  logic              fifoIrqIn,
  output logic              irqOut
);

  ctlStrobe_t strb;
  logic [1:0] modeField;

  irda_mic_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .modeField(modeField),
    .strb     (strb)
  );

  irda_mic_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWData (regWData),
    .evtPulse (evtPulse),
    .fifoIrqIn(fifoIrqIn),
    .regRData (regRData),
    .modeField(modeField),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/irda_mic_top_tb_top.sv
`timescale 1ns/1ps
module irda_mic_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [15:0] regWData = '0;
  logic [15:0] regRData;
  logic [4:0]  evtPulse = '0;
  logic        fifoIrqIn = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irda_mic_top #(.ADDR_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWData(regWData), .regRData(regRData), .evtPulse(evtPulse),
    .fifoIrqIn(fifoIrqIn), .irqOut(irqOut)
  );

  function automatic int bitOf(input int e);
    case (e)
      0: return 15;
      1: return 11;
      2: return 9;
      3: return 8;
      default: return 7;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    regAddr = 3'(a); regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWData = '0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    regAddr = 3'(a);
    #1 d = regRData;
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    evtPulse = '0; evtPulse[e] = 1'b1;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic chkReg(input string tag, input int a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    #1 chk(tag, 16'(irqOut), 16'(exp));
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkReg("R1 mode reset", 0, 16'h0111);
    chkReg("R1 slow mask reset", 2, 16'h8B80);
    chkReg("R1 fast mask reset", 5, 16'h8B80);
    chkReg("R1 slow src reset", 1, 16'h0000);
    chkReg("R1 fast src reset", 4, 16'h0000);
    chkIrq("R1 irq reset", 1'b0);

    // R2 mode register stores only defined bits; other addresses read 0
    wr(0, 16'hFFFF);
    chkReg("R2 mode stored bits", 0, 16'hC111);
    chkReg("R2 clear addr reads 0", 3, 16'h0000);
    chkReg("R2 clear addr reads 0 fast", 6, 16'h0000);
    chkReg("R2 addr7 reads 0", 7, 16'h0000);
    // R7 mask stores only event bits
    wr(2, 16'hFFFF);
    chkReg("R7 mask stored bits", 2, 16'h8B80);

    // Sweep: every mode code x every event
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 5; e++) begin
        int bank;
        int srcA;
        int maskA;
        int clrA;
        int grp;
        logic [15:0] bitv;
        bank = (m == 0) ? 0 : (m == 1) ? -1 : 1;
        bitv = 16'(1) << bitOf(e);
        wr(0, 16'(m) << 14);
        wr(3, 16'hFFFF); wr(6, 16'hFFFF);
        wr(2, 16'h0000); wr(5, 16'h0000);
        pulse(e);
        // R3 routing by mode field
        chkReg("R3 slow src", 1, (bank == 0) ? bitv : 16'h0000);
        chkReg("R3 fast src", 4, (bank == 1) ? bitv : 16'h0000);
        chkIrq("R8 irq unmasked", bank >= 0);
        if (bank >= 0) begin
          srcA  = (bank == 0) ? 1 : 4;
          maskA = srcA + 1;
          clrA  = srcA + 2;
          grp   = (bank == 0) ? 0 : 4;
          wr(maskA, bitv);
          chkIrq("R7 irq masked bit", 1'b0);
          chkReg("R4 src kept while masked", srcA, bitv);
          wr(srcA, 16'h0000);
          chkReg("R4 src write ignored", srcA, bitv);
          wr(maskA, 16'h0000);
          wr(0, (16'(m) << 14) | (16'(1) << grp));
          chkIrq("R8 group mask blocks", 1'b0);
          wr(0, 16'(m) << 14);
          chkIrq("R9 irq follows group unmask", 1'b1);
          wr(clrA, ~bitv);
          chkReg("R5 zero bits keep src", srcA, bitv);
          wr(clrA, bitv);
          chkReg("R5 one bit clears src", srcA, 16'h0000);
          chkIrq("R5 irq after clear", 1'b0);
        end
      end
    end

    // R4 masked event still latches
    wr(0, 16'h0000);
    wr(2, 16'h8B80);
    pulse(1);
    chkReg("R4 latch while masked", 1, 16'h0800);
    chkIrq("R7 masked no irq", 1'b0);

    // R6 event and clear collide
    wr(2, 16'h0000);
    wr(3, 16'hFFFF);
    @(negedge clk);
    regAddr = 3'd3; regWData = 16'h0100; regWr = 1'b1; evtPulse = 5'b01000;
    @(negedge clk);
    regWr = 1'b0; evtPulse = '0; regWData = '0;
    chkReg("R6 event wins over clear", 1, 16'h0100);
    wr(3, 16'hFFFF);
    chkReg("R6 later clear works", 1, 16'h0000);

    // R8 FIFO group
    wr(0, 16'h0100);
    fifoIrqIn = 1'b1;
    chkIrq("R8 fifo group masked", 1'b0);
    wr(0, 16'h0000);
    chkIrq("R8 fifo group open", 1'b1);
    fifoIrqIn = 1'b0;
    chkIrq("R8 fifo request gone", 1'b0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule